// File: doc/BRIEF.md
# Banked Indirect Register Bridge

This block is a slave-side register file that sits behind a management interface. A host reaches a handful of 16-bit registers directly over a simple synchronous register port (address, write data, write strobe, read strobe, registered read data). Beyond those, several banks of extended registers are reachable only through a window made of three direct registers. The host stages a value in a staging register and issues a command word that names a bank and an offset. The command then either copies the staged value into that location or copies the location into a result register, which the host reads on its next access.

Bank 0 of the window is the direct register space itself, so every direct register is also reachable through the window. The direct space also holds a latched interrupt source register that clears when read, a mask register that gates a registered interrupt output, and a control register whose top bit starts a self-clearing soft reset. The soft reset returns every register in every bank to zero and holds for a fixed number of clocks.

Top module: `bank_window_regs`

## Requirements
- R1: A host write to direct address 0x14 is a command: bit 12 requests a read, bit 11 requests a write, bits 10:8 select the bank, bits 7:0 select the offset. Reading 0x14 returns the last bank and offset in bits 10:0, with bits 15:11 zero.
- R2: A command with the write flag copies the current content of the staging register (direct address 0x16) into the selected location within one clock.
- R3: A command with only the read flag copies the selected location into the result register (direct address 0x15) within one clock, so the next host read of 0x15 returns it. Host writes to 0x15 have no effect.
- R4: Bank 0 is the direct space: a window write to bank 0 is seen by a direct read of that offset, and a window read of bank 0 returns what a direct read would, including clearing the interrupt source when the offset is 0x18.
- R5: Banks 1 to 4 are separate spaces; the same offset in two banks holds two independent values.
- R6: A command with both flags set performs only the write and leaves the result register unchanged.
- R7: Banks 5 to 7, and offsets at or above the bank depth (32 words), drop writes and read back as zero.
- R8: Interrupt source bits (direct address 0x18) latch on a one-cycle event pulse and clear when the register is read; an event in the same cycle as the clearing read stays latched.
- R9: The interrupt output is high one clock after any source bit is set whose mask bit (direct address 0x19; bit 2 link-up, bit 1 link-down) is set, and stays low for unmasked sources.
- R10: Writing 1 to bit 15 of direct address 0x00 starts a soft reset: bit 15 reads 1 for 16 clocks, then 0; during that time host writes are ignored, and afterwards every register in every bank reads zero.
- R11: After the reset input, all registers read zero and the interrupt output is low.
- R12: Host read data is registered: it reflects the addressed register one clock after the read strobe and holds between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Direct register address |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Registered read data |
| irq_event | input | IRQ_W (16) | One-cycle interrupt event pulses |
| irq_o | output | 1 | Registered masked interrupt |

## Verification
The bench builds the block with four extended banks of 32 words each, a 32-word direct space, a 16-clock soft reset hold and 16 interrupt sources. With four banks the bank field still reaches the unbacked banks 5 to 7, and a 32-word depth lets an 8-bit offset such as 0x40 fall outside the storage. The short hold lets the bench watch the reset bit set, then clear, and confirm that all banks return to zero within a few dozen clocks.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  localparam int DW = 16;
  localparam int BANK_W = 3;
  localparam int OFF_W = 8;

  localparam logic [OFF_W-1:0] A_CTRL  = 8'h00;
  localparam logic [OFF_W-1:0] A_CMD   = 8'h14;
  localparam logic [OFF_W-1:0] A_RDATA = 8'h15;
  localparam logic [OFF_W-1:0] A_WDATA = 8'h16;
  localparam logic [OFF_W-1:0] A_SRC   = 8'h18;
  localparam logic [OFF_W-1:0] A_MASK  = 8'h19;

  localparam int CMD_RD_BIT = 12;
  localparam int CMD_WR_BIT = 11;
  localparam int CMD_BANK_LO = 8;
  localparam int CTRL_RST_BIT = 15;
endpackage

// File: rtl/bwr_ext_bank.sv
module bwr_ext_bank import bwr_pkg::*; #(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             we,
  input  logic [OFF_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic          in_range;

  assign in_range = int'(addr) < DEPTH;

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && in_range) begin
      mem[addr[AW-1:0]] <= wdata;
    end
  end

  assign rdata = in_range ? mem[addr[AW-1:0]] : '0;
endmodule

// File: rtl/bwr_irq.sv
module bwr_irq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] event_i,
  input  logic         rd_clear,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  output logic [W-1:0] src_o,
  output logic [W-1:0] mask_o,
  output logic         irq_o
);
  always_ff @(posedge clk) begin
    if (clr) begin
      src_o  <= '0;
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      src_o <= (rd_clear ? '0 : src_o) | event_i;
      if (mask_we) mask_o <= mask_wdata;
      irq_o <= |(src_o & mask_o);
    end
  end
endmodule

// File: rtl/bwr_softrst.sv
module bwr_softrst #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(HOLD - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/bank_window_regs.sv
module bank_window_regs import bwr_pkg::*; #(
  parameter int DIR_DEPTH = 32,
  parameter int EXT_DEPTH = 32,
  parameter int EXT_BANKS = 4,
  parameter int RST_HOLD  = 16,
  parameter int IRQ_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OFF_W-1:0] host_addr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_wr,
  input  logic             host_rd,
  output logic [DW-1:0]    host_rdata,
  input  logic [IRQ_W-1:0] irq_event,
  output logic             irq_o
);
  localparam int DAW = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1;
  localparam int CMDQ_W = BANK_W + OFF_W;

  logic              busy;
  logic              rst_int;
  logic              host_we;
  logic              cmd_go, cmd_wr, cmd_rd;
  logic [BANK_W-1:0] cmd_bank;
  logic [OFF_W-1:0]  cmd_off;
  logic              dir_we;
  logic [OFF_W-1:0]  dir_wa;
  logic [DW-1:0]     dir_wd;
  logic [14:0]       ctrl_q;
  logic [CMDQ_W-1:0] cmd_q;
  logic [DW-1:0]     rdata_q, wdata_q;
  logic [DW-1:0]     dir_mem [DIR_DEPTH];
  logic [IRQ_W-1:0]  irq_src, irq_mask;
  logic [DW-1:0]     src16, mask16;
  logic [DW-1:0]     ext_rd [EXT_BANKS];
  logic [DW-1:0]     host_rv, win_rv;
  logic              src_clear, soft_go;

  assign rst_int  = rst | busy;
  assign host_we  = host_wr && !busy;
  assign cmd_bank = host_wdata[CMD_BANK_LO +: BANK_W];
  assign cmd_off  = host_wdata[OFF_W-1:0];
  assign cmd_go   = host_we && (host_addr == A_CMD);
  assign cmd_wr   = cmd_go && host_wdata[CMD_WR_BIT];
  assign cmd_rd   = cmd_go && host_wdata[CMD_RD_BIT] && !host_wdata[CMD_WR_BIT];

  // one shared write port into the direct space: host first, window second
  always_comb begin
    dir_we = 1'b0;
    dir_wa = host_addr;
    dir_wd = host_wdata;
    if (host_we && host_addr != A_CMD) begin
      dir_we = 1'b1;
    end else if (cmd_wr && cmd_bank == '0) begin
      dir_we = 1'b1;
      dir_wa = cmd_off;
      dir_wd = wdata_q;
    end
  end

  assign soft_go = dir_we && (dir_wa == A_CTRL) && dir_wd[CTRL_RST_BIT];

  bwr_softrst #(.HOLD(RST_HOLD)) u_rst (
    .clk(clk), .rst(rst), .start(soft_go), .busy(busy)
  );

  always_comb begin
    src16  = '0;
    mask16 = '0;
    src16[IRQ_W-1:0]  = irq_src;
    mask16[IRQ_W-1:0] = irq_mask;
  end

  function automatic logic [DW-1:0] dir_read(input logic [OFF_W-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    case (a)
      A_CTRL:  v = {busy, ctrl_q};
      A_CMD:   v[CMDQ_W-1:0] = cmd_q;
      A_RDATA: v = rdata_q;
      A_WDATA: v = wdata_q;
      A_SRC:   v = src16;
      A_MASK:  v = mask16;
      default: if (int'(a) < DIR_DEPTH) v = dir_mem[a[DAW-1:0]];
    endcase
    return v;
  endfunction

  assign host_rv = dir_read(host_addr);

  always_comb begin
    win_rv = '0;
    if (cmd_bank == '0) begin
      win_rv = dir_read(cmd_off);
    end else begin
      for (int b = 0; b < EXT_BANKS; b++)
        if (int'(cmd_bank) == b + 1) win_rv = ext_rd[b];
    end
  end

  assign src_clear = (host_rd && host_addr == A_SRC) ||
                     (cmd_rd && cmd_bank == '0 && cmd_off == A_SRC);

  bwr_irq #(.W(IRQ_W)) u_irq (
    .clk(clk), .clr(rst_int), .event_i(irq_event), .rd_clear(src_clear),
    .mask_we(dir_we && dir_wa == A_MASK), .mask_wdata(dir_wd[IRQ_W-1:0]),
    .src_o(irq_src), .mask_o(irq_mask), .irq_o(irq_o)
  );

  genvar g;
  generate
    for (g = 0; g < EXT_BANKS; g++) begin : g_bank
      bwr_ext_bank #(.DEPTH(EXT_DEPTH)) u_bank (
        .clk(clk), .clr(rst_int),
        .we(cmd_wr && int'(cmd_bank) == g + 1),
        .addr(cmd_off), .wdata(wdata_q), .rdata(ext_rd[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_int) begin
      ctrl_q  <= '0;
      cmd_q   <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      for (int i = 0; i < DIR_DEPTH; i++) dir_mem[i] <= '0;
    end else begin
      if (cmd_go) cmd_q <= {cmd_bank, cmd_off};
      if (cmd_rd) rdata_q <= win_rv;
      if (dir_we) begin
        case (dir_wa)
          A_CTRL:  ctrl_q  <= dir_wd[14:0];
          A_WDATA: wdata_q <= dir_wd;
          A_CMD, A_RDATA, A_SRC, A_MASK: ;
          default: if (int'(dir_wa) < DIR_DEPTH) dir_mem[dir_wa[DAW-1:0]] <= dir_wd;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else if (host_rd) host_rdata <= host_rv;
  end
endmodule

// File: rtl/bwr_checker.sv
module bwr_checker #(
  parameter int RST_HOLD = 16,
  parameter int IRQ_W    = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       host_addr,
  input logic             host_rd,
  input logic [15:0]      host_rdata,
  input logic [IRQ_W-1:0] irq_event,
  input logic             irq_o,
  input logic             busy,
  input logic [IRQ_W-1:0] src,
  input logic [IRQ_W-1:0] mask
);
  localparam int CW = $clog2(RST_HOLD + 2);
  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst) busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  // R10: the hold never exceeds its length
  a_r10_hold_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(busy_cnt) < RST_HOLD));

  // R10: the hold lasts exactly its length
  a_r10_hold_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (int'(busy_cnt) == RST_HOLD));

  // R10: bit 15 of the control register is visible while held
  a_r10_busy_visible: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 8'h00 && busy) |=> host_rdata[15]);

  // R8: an event always latches
  a_r8_event_latch: assert property (@(posedge clk) disable iff (rst)
    (!busy && irq_event != '0) |=> ((src & $past(irq_event)) == $past(irq_event)));

  // R8: a read with no event leaves the source empty
  a_r8_read_clear: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == 8'h18 && irq_event == '0) |=> (src == '0));

  // R9: output follows masked sources one clock later
  a_r9_irq_follow: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy) && !busy) |-> (irq_o == $past(|(src & mask))));

  // R12: read data holds between reads
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(host_rdata));
endmodule

bind bank_window_regs bwr_checker #(.RST_HOLD(RST_HOLD), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd),
  .host_rdata(host_rdata), .irq_event(irq_event), .irq_o(irq_o),
  .busy(busy), .src(irq_src), .mask(irq_mask)
);

// File: tb/bank_window_regs_test.sv
module bank_window_regs_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [15:0] host_rdata;
  logic [15:0] irq_event = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  bank_window_regs #(.DIR_DEPTH(32), .EXT_DEPTH(32), .EXT_BANKS(4),
                     .RST_HOLD(16), .IRQ_W(16)) uut (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .irq_event(irq_event), .irq_o(irq_o)
  );

  function automatic logic [15:0] wcmd(input int bank, input int off);
    return 16'h0800 | 16'((bank << 8) | off);
  endfunction
  function automatic logic [15:0] rcmd(input int bank, input int off);
    return 16'h1000 | 16'((bank << 8) | off);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // all driver tasks start and end at a falling edge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  // monitor: data is registered at the edge that samples the read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (host_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "scoreboard underflow", host_rdata, '0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(host_rdata === e, t, host_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    rd(8'h00, 16'h0000, "R11 ctrl");
    rd(8'h19, 16'h0000, "R11 mask");
    rd(8'h18, 16'h0000, "R11 source");
    check(irq_o === 1'b0, "R11 irq", {15'h0, irq_o}, 16'h0);

    // R2 write then R3 read back through the window, R1 command readback
    wr(8'h16, 16'hA5A5);
    wr(8'h14, wcmd(1, 3));
    wr(8'h14, rcmd(1, 3));
    rd(8'h15, 16'hA5A5, "R2 window write bank1");
    rd(8'h14, 16'h0103, "R1 command readback");

    // R5 separate banks
    wr(8'h16, 16'h1234);
    wr(8'h14, wcmd(4, 3));
    wr(8'h14, rcmd(1, 3));
    rd(8'h15, 16'hA5A5, "R5 bank1 untouched");
    wr(8'h14, rcmd(4, 3));
    rd(8'h15, 16'h1234, "R5 bank4 value");

    // R3 host writes to result register ignored
    wr(8'h15, 16'h9999);
    rd(8'h15, 16'h1234, "R3 result write ignored");

    // R4 bank 0 is the direct space
    wr(8'h16, 16'h0BEE);
    wr(8'h14, wcmd(0, 5));
    rd(8'h05, 16'h0BEE, "R4 window write direct");
    wr(8'h07, 16'h7777);
    wr(8'h14, rcmd(0, 7));
    rd(8'h15, 16'h7777, "R4 window read direct");

    // R6 both flags: write only
    wr(8'h16, 16'h4242);
    wr(8'h14, 16'h1800 | 16'h0201);
    rd(8'h15, 16'h7777, "R6 result unchanged");
    wr(8'h14, rcmd(2, 1));
    rd(8'h15, 16'h4242, "R6 write performed");

    // R7 unbacked banks and offsets
    wr(8'h16, 16'hFFFF);
    wr(8'h14, wcmd(5, 1));
    wr(8'h14, rcmd(5, 1));
    rd(8'h15, 16'h0000, "R7 bank5 reads zero");
    wr(8'h14, rcmd(1, 1));
    rd(8'h15, 16'h0000, "R7 bank5 write not aliased");
    wr(8'h14, wcmd(1, 8'h40));
    wr(8'h14, rcmd(1, 8'h40));
    rd(8'h15, 16'h0000, "R7 offset beyond depth");

    // R9 masked interrupt
    wr(8'h19, 16'h0006);
    rd(8'h19, 16'h0006, "R9 mask readback");
    irq_event = 16'h0004;
    @(negedge clk);
    irq_event = '0;
    @(negedge clk);
    check(irq_o === 1'b1, "R9 irq raised", {15'h0, irq_o}, 16'h1);
    rd(8'h18, 16'h0004, "R8 source latched");
    @(negedge clk);
    check(irq_o === 1'b0, "R9 irq dropped after clear", {15'h0, irq_o}, 16'h0);
    rd(8'h18, 16'h0000, "R8 source cleared");

    // R9 unmasked source does not raise the output
    irq_event = 16'h0001;
    @(negedge clk);
    irq_event = '0;
    @(negedge clk);
    @(negedge clk);
    check(irq_o === 1'b0, "R9 unmasked source", {15'h0, irq_o}, 16'h0);
    rd(8'h18, 16'h0001, "R8 unmasked latched");

    // R8 event in the same cycle as the clearing read survives
    irq_event = 16'h0002;
    @(negedge clk);
    rd(8'h18, 16'h0002, "R8 read with event");
    irq_event = '0;
    rd(8'h18, 16'h0002, "R8 event survived");
    rd(8'h18, 16'h0000, "R8 cleared again");

    // R4 window read of the source register clears it
    irq_event = 16'h0004;
    @(negedge clk);
    irq_event = '0;
    wr(8'h14, rcmd(0, 8'h18));
    rd(8'h15, 16'h0004, "R4 window read source");
    rd(8'h18, 16'h0000, "R4 window read cleared source");

    // R10 soft reset
    wr(8'h00, 16'h0012);
    rd(8'h00, 16'h0012, "R10 ctrl store");
    wr(8'h00, 16'h8012);
    rd(8'h00, 16'h8012, "R10 bit set first cycle");
    rd(8'h00, 16'h8000, "R10 held registers cleared");
    wr(8'h19, 16'hFFFF);
    repeat (20) @(negedge clk);
    rd(8'h00, 16'h0000, "R10 bit self-cleared");
    rd(8'h19, 16'h0000, "R10 write during hold ignored");
    rd(8'h05, 16'h0000, "R10 direct space cleared");
    rd(8'h16, 16'h0000, "R10 staging cleared");
    wr(8'h14, rcmd(4, 3));
    rd(8'h15, 16'h0000, "R10 bank4 cleared");
    // R12 read data holds between reads
    repeat (3) @(negedge clk);
    check(host_rdata === 16'h0000, "R12 hold", host_rdata, 16'h0000);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "scoreboard leftover", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule